// File: doc/BRIEF.md
# Valley-Switching Gate Timing Controller

This block decides when the power switch of a variable-frequency flyback stage turns on and off. It works on a fixed system clock and sees three single-bit comparator results: a zero-current detect bit taken from the auxiliary winding, a current-sense trip bit that is high when the sensed switch current exceeds its reference, and a flag that tells whether the multiplier output is in its upper range. It produces one gate-enable bit for the driver stage, plus a one-cycle marker for turn-ons that came from the watchdog rather than from a valley.

While the switch is on, the current-sense trip is masked for a fixed leading-edge window. After that window, the trip ends the pulse. While the switch is off, the zero-current bit is synchronised and masked for a blanking time that depends on the multiplier flag. Falling crossings after that time are counted, and the switch turns on at the second one, but never before a minimum off-time has passed. If no second valley arrives, a watchdog forces the turn-on at a fixed off-time. All durations are clock-cycle counts given as parameters. The defaults fit a 50 MHz clock: 400 ns leading-edge window, 5.5 us minimum off-time, 190 us watchdog, and 1.6 us or 0.8 us ZCD blanking.

Top module: `vsw_gate_ctrl`

## Requirements
- R1: While `rstN` is low or `enable` is low, `gateOn` and `forcedOn` are low and every counter is cleared. The first cycle with both high starts a fresh OFF interval, timed exactly like one that begins at a turn-off.
- R2: The switch turns on at the second counted falling crossing of `zcdIn` within one OFF interval. Take a crossing whose low level is first applied during OFF cycle n, where cycle 1 is the first cycle after turn-off. If the minimum off-time is already met, `gateOn` is high from OFF cycle n+3 on, so the OFF interval lasts n+2 cycles. This latency comes from two synchroniser stages plus the edge detector.
- R3: An OFF interval never lasts fewer than MIN_OFF_CYC cycles (275 by default). A second crossing that arrives earlier turns the switch on after exactly MIN_OFF_CYC cycles.
- R4: If no crossing-driven turn-on has happened, the switch turns on after exactly RESTART_CYC cycles of OFF time (9500 by default). In the first ON cycle of that turn-on, `forcedOn` is high for one cycle. If the second crossing would also turn the switch on in that same cycle, `forcedOn` stays low.
- R5: During the first LEB_CYC ON cycles (20 by default), `csTrip` is ignored. If `csTrip` is first high during ON cycle m, the ON interval lasts max(LEB_CYC, m) cycles.
- R6: A crossing applied during OFF cycle n is counted only if n+1 is at least the blank count. The blank count is ZB_HI_CYC (80) when `multHigh` is 1 and ZB_LO_CYC (40) when it is 0.
- R7: The crossing count clears at every turn-off and whenever `enable` is low. A single crossing in one interval therefore never combines with a single crossing in a later interval.
- R8: A single counted crossing alone never turns the switch on. The interval then ends through the watchdog of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds the gate off and clears all timers |
| zcdIn | input | 1 | Zero-current comparator bit, asynchronous, high above threshold |
| csTrip | input | 1 | Current-sense comparator bit, high when sense level is above the reference |
| multHigh | input | 1 | Multiplier output is in its upper range; selects the longer ZCD blank |
| gateOn | output | 1 | Gate enable for the driver stage |
| forcedOn | output | 1 | One-cycle marker on a watchdog-forced turn-on |

## Verification
The checker watches the interval lengths on every cycle. No OFF interval may be shorter than the minimum or reach past the watchdog limit, and a forced turn-on must land exactly on the watchdog count. No pulse may end inside the blanking window, every turn-off must follow a trip or a disable, and disable must force the gate off. The exact turn-on instant depends on where the valleys fall relative to the blanking window and the minimum off-time, so only the bench scenarios can show it. They cover the synchroniser latency, the blank-boundary crossings for both multiplier ranges, the count clearing between intervals and on disable, and the tie between a late valley and the watchdog.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  // Strobes from the control FSM to the timing datapath.
  typedef struct packed {
    logic offPhase;  // gate currently low
    logic startOn;   // turn-on happens at this edge
    logic startOff;  // turn-off happens at this edge
  } vswStrobe_t;
endpackage

// File: rtl/vsw_datapath.sv
module vsw_datapath
  import vsw_pkg::*;
#(
  parameter int LEB_CYC     = 20,
  parameter int MIN_OFF_CYC = 275,
  parameter int RESTART_CYC = 9500,
  parameter int ZB_HI_CYC   = 80,
  parameter int ZB_LO_CYC   = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       zcdIn,
  input  logic       multHigh,
  input  vswStrobe_t strobe,
  output logic       valleyArmed,
  output logic       minOffDone,
  output logic       restartDue,
  output logic       lebDone
);
  localparam int OFF_W = $clog2(RESTART_CYC + 1);
  localparam int ON_W  = $clog2(LEB_CYC + 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(RESTART_CYC - 1);
  localparam logic [OFF_W-1:0] MIN_LAST = OFF_W'(MIN_OFF_CYC - 1);
  localparam logic [OFF_W-1:0] BLANK_HI = OFF_W'(ZB_HI_CYC);
  localparam logic [OFF_W-1:0] BLANK_LO = OFF_W'(ZB_LO_CYC);
  localparam logic [ON_W-1:0]  LEB_LAST = ON_W'(LEB_CYC - 1);

  // Synchroniser stages followed by one history flop for edge detection.
  logic [SYNC_STAGES:0] zPipe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zPipe <= '0;
    else       zPipe <= {zPipe[SYNC_STAGES-1:0], zcdIn};
  end

  logic zFall;
  assign zFall = zPipe[SYNC_STAGES] & ~zPipe[SYNC_STAGES-1];

  logic [OFF_W-1:0] offCnt;
  logic [ON_W-1:0]  onCnt;
  logic [1:0]       crossCnt;
  logic [OFF_W-1:0] blankCnt;
  logic             fallValid;

  assign blankCnt  = multHigh ? BLANK_HI : BLANK_LO;
  assign fallValid = strobe.offPhase && zFall && (offCnt >= blankCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              offCnt <= '0;
    else if (!enable || strobe.startOff)    offCnt <= '0;
    else if (strobe.offPhase && offCnt != OFF_LAST) offCnt <= offCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              crossCnt <= '0;
    else if (!enable || strobe.startOff)    crossCnt <= '0;
    else if (fallValid && crossCnt != 2'd2) crossCnt <= crossCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              onCnt <= '0;
    else if (!enable || strobe.startOn)     onCnt <= '0;
    else if (!strobe.offPhase && onCnt != LEB_LAST) onCnt <= onCnt + 1'b1;
  end

  assign valleyArmed = (crossCnt == 2'd2) || (crossCnt == 2'd1 && fallValid);
  assign minOffDone  = offCnt >= MIN_LAST;
  assign restartDue  = offCnt == OFF_LAST;
  assign lebDone     = onCnt == LEB_LAST;
endmodule

// File: rtl/vsw_control.sv
module vsw_control
  import vsw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       csTrip,
  input  logic       valleyArmed,
  input  logic       minOffDone,
  input  logic       restartDue,
  input  logic       lebDone,
  output vswStrobe_t strobe,
  output logic       gateOn,
  output logic       forcedOn
);
  logic valleyGo;
  logic startOn;
  logic startOff;

  always_comb begin
    valleyGo = minOffDone && valleyArmed;
    startOn  = enable && !gateOn && (valleyGo || restartDue);
    startOff = enable && gateOn && lebDone && csTrip;
    strobe.offPhase = !gateOn;
    strobe.startOn  = startOn;
    strobe.startOff = startOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOn   <= 1'b0;
      forcedOn <= 1'b0;
    end else if (!enable) begin
      gateOn   <= 1'b0;
      forcedOn <= 1'b0;
    end else begin
      if (startOn)       gateOn <= 1'b1;
      else if (startOff) gateOn <= 1'b0;
      forcedOn <= startOn && !valleyGo;
    end
  end
endmodule

// File: rtl/vsw_gate_ctrl.sv
module vsw_gate_ctrl
  import vsw_pkg::*;
#(
  parameter int LEB_CYC     = 20,
  parameter int MIN_OFF_CYC = 275,
  parameter int RESTART_CYC = 9500,
  parameter int ZB_HI_CYC   = 80,
  parameter int ZB_LO_CYC   = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic zcdIn,
  input  logic csTrip,
  input  logic multHigh,
  output logic gateOn,
  output logic forcedOn
);
  vswStrobe_t strobe;
  logic valleyArmed;
  logic minOffDone;
  logic restartDue;
  logic lebDone;

  vsw_datapath #(
    .LEB_CYC(LEB_CYC), .MIN_OFF_CYC(MIN_OFF_CYC), .RESTART_CYC(RESTART_CYC),
    .ZB_HI_CYC(ZB_HI_CYC), .ZB_LO_CYC(ZB_LO_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .zcdIn(zcdIn), .multHigh(multHigh),
    .strobe(strobe), .valleyArmed(valleyArmed), .minOffDone(minOffDone),
    .restartDue(restartDue), .lebDone(lebDone)
  );

  vsw_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .csTrip(csTrip),
    .valleyArmed(valleyArmed), .minOffDone(minOffDone), .restartDue(restartDue),
    .lebDone(lebDone), .strobe(strobe), .gateOn(gateOn), .forcedOn(forcedOn)
  );
endmodule

// File: rtl/vsw_gate_ctrl_sva.sv
module vsw_gate_ctrl_sva #(
  parameter int LEB_CYC     = 20,
  parameter int MIN_OFF_CYC = 275,
  parameter int RESTART_CYC = 9500
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic csTrip,
  input logic gateOn,
  input logic forcedOn
);
  localparam int RW = $clog2(RESTART_CYC + 2);
  localparam logic [RW-1:0] LOW_MAX  = RW'(RESTART_CYC + 1);
  localparam logic [RW-1:0] HIGH_MAX = RW'(LEB_CYC);

  // Run-length counters of the observed gate level.
  logic [RW-1:0] lowRun;
  logic [RW-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   lowRun <= '0;
    else if (!enable || gateOn)  lowRun <= '0;
    else if (lowRun != LOW_MAX)  lowRun <= lowRun + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   highRun <= '0;
    else if (!enable || !gateOn) highRun <= '0;
    else if (highRun != HIGH_MAX) highRun <= highRun + 1'b1;
  end

  p_enable_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!gateOn && !forcedOn));

  p_min_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> (lowRun >= RW'(MIN_OFF_CYC)));

  p_restart_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> (lowRun < RW'(RESTART_CYC)));

  p_forced_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    forcedOn |-> ($rose(gateOn) && lowRun == RW'(RESTART_CYC)));

  p_leb_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOn) && $past(enable)) |-> (highRun >= RW'(LEB_CYC)));

  p_trip_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> (!$past(enable) || $past(csTrip)));
endmodule

bind vsw_gate_ctrl vsw_gate_ctrl_sva #(
  .LEB_CYC(LEB_CYC), .MIN_OFF_CYC(MIN_OFF_CYC), .RESTART_CYC(RESTART_CYC)
) u_sva (
  .clk(clk), .rstN(rstN), .enable(enable), .csTrip(csTrip),
  .gateOn(gateOn), .forcedOn(forcedOn)
);

// File: tb/vsw_gate_ctrl_tb.sv
`timescale 1ns/1ps
module vsw_gate_ctrl_tb;
  localparam int LEB     = 20;
  localparam int MINOFF  = 275;
  localparam int RESTART = 9500;
  localparam int BHI     = 80;
  localparam int BLO     = 40;
  localparam int WD_CYC  = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic zcdIn = 1'b0;
  logic csTrip = 1'b0;
  logic multHigh = 1'b0;
  logic gateOn;
  logic forcedOn;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vsw_gate_ctrl u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .zcdIn(zcdIn), .csTrip(csTrip),
    .multHigh(multHigh), .gateOn(gateOn), .forcedOn(forcedOn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ZCD high for five cycles before each falling crossing count.
  function automatic bit zLevel(input int n, input int f1, input int f2, input int f3);
    return (f1 != 0 && n >= f1 - 5 && n < f1) ||
           (f2 != 0 && n >= f2 - 5 && n < f2) ||
           (f3 != 0 && n >= f3 - 5 && n < f3);
  endfunction

  // Count of the second crossing that survives the blank, or -1.
  function automatic int secondValid(input bit mh, input int f1, input int f2, input int f3);
    int blank = mh ? BHI : BLO;
    int seen = 0;
    int fs[3] = '{f1, f2, f3};
    for (int i = 0; i < 3; i++) begin
      if (fs[i] != 0 && fs[i] + 1 >= blank) begin
        seen++;
        if (seen == 2) return fs[i];
      end
    end
    return -1;
  endfunction

  function automatic int expOff(input bit mh, input int f1, input int f2, input int f3);
    int n2 = secondValid(mh, f1, f2, f3);
    int t;
    if (n2 < 0) return RESTART;
    t = (n2 + 2 < MINOFF) ? MINOFF : n2 + 2;
    return (t > RESTART) ? RESTART : t;
  endfunction

  function automatic int expForced(input bit mh, input int f1, input int f2, input int f3);
    int n2 = secondValid(mh, f1, f2, f3);
    return (n2 >= 0 && n2 + 2 <= RESTART) ? 0 : 1;
  endfunction

  // Entered at the negedge showing the first OFF sample; leaves at the first ON sample.
  task automatic offPhase(input bit mh, input int f1, input int f2, input int f3,
                          input string tag);
    int len = 0;
    multHigh = mh;
    while (!gateOn && len < RESTART + 50) begin
      len++;
      csTrip = 1'b0;
      zcdIn = zLevel(len, f1, f2, f3);
      @(negedge clk);
    end
    zcdIn = 1'b0;
    chk({tag, " off length"}, len, expOff(mh, f1, f2, f3));
    chk({tag, " forced flag R4"}, int'(forcedOn), expForced(mh, f1, f2, f3));
  endtask

  // Entered at the first ON sample; leaves at the first OFF sample.
  task automatic onPhase(input int csAt, input string tag);
    int len = 0;
    zcdIn = 1'b0;
    while (gateOn && len < RESTART) begin
      len++;
      csTrip = (len >= csAt);
      @(negedge clk);
    end
    csTrip = 1'b0;
    chk({tag, " on length R5"}, len, (csAt > LEB) ? csAt : LEB);
  endtask

  initial begin
    #(WD_CYC * 20);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED1234);
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 gate in reset", int'(gateOn), 0);
    chk("R1 forced in reset", int'(forcedOn), 0);
    rstN = 1'b1;
    // R1 R4: first interval after reset ends by watchdog
    offPhase(1'b0, 0, 0, 0, "R1 R4 post-reset");
    onPhase(5, "R5 short trip");
    // R3: valleys before minimum off-time
    offPhase(1'b0, 100, 200, 0, "R3 early valleys");
    onPhase(35, "R5 late trip");
    // R2: valley after minimum, latency n+2
    offPhase(1'b1, 300, 500, 0, "R2 late valley");
    onPhase(LEB, "R5 trip at window end");
    // R6: crossing inside long blank ignored
    offPhase(1'b1, 60, 300, 420, "R6 high blank");
    onPhase(1, "R5 trip from start");
    offPhase(1'b0, 60, 300, 420, "R6 low blank");
    onPhase(21, "R5 trip one past");
    // R6 boundary: count 38 ignored, 39 counted
    offPhase(1'b0, 38, 300, 400, "R6 boundary ignored");
    onPhase(10, "R5");
    offPhase(1'b0, 39, 300, 400, "R6 boundary counted");
    onPhase(10, "R5");
    // R8 and R7: single crossings never combine across intervals
    offPhase(1'b0, 200, 0, 0, "R8 single crossing");
    onPhase(10, "R5");
    offPhase(1'b0, 150, 0, 0, "R7 no carry");
    onPhase(10, "R5");
    // R4 tie: late second valley versus watchdog
    offPhase(1'b0, 200, RESTART - 3, 0, "R2 R4 late valley");
    onPhase(10, "R5");
    offPhase(1'b0, 200, RESTART - 2, 0, "R4 tie");
    onPhase(10, "R5");
    // R1 R7: disable mid-OFF clears the crossing count
    multHigh = 1'b0;
    for (int n = 1; n <= 200; n++) begin
      zcdIn = zLevel(n, 150, 0, 0);
      @(negedge clk);
    end
    chk("R2 no turn-on before second valley", int'(gateOn), 0);
    enable = 1'b0;
    zcdIn = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R1 gate low while disabled", int'(gateOn), 0);
    end
    enable = 1'b1;
    offPhase(1'b0, 100, 0, 0, "R1 R7 re-enable");
    // R1: disable during ON drops the gate on the next cycle
    for (int k = 1; k <= 30; k++) begin
      csTrip = 1'b0;
      @(negedge clk);
    end
    chk("R1 still on without trip", int'(gateOn), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R1 gate off after disable", int'(gateOn), 0);
    enable = 1'b1;
    offPhase(1'b1, 100, 400, 0, "R1 R2 after on-disable");
    // Random intervals
    for (int i = 0; i < 30; i++) begin
      bit mh = 1'($urandom % 2);
      int f1 = 6 + int'($urandom % 500);
      int f2 = f1 + 6 + int'($urandom % 700);
      int cs = 1 + int'($urandom % 60);
      if ($urandom % 10 == 0) f2 = 0;
      onPhase(cs, "R5 random");
      offPhase(mh, f1, f2, 0, "R2 R3 R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule